// File: doc/BRIEF.md
# Cluster L1 Coherence Tracker (Write-Through, Two Cores)

This block follows the coherence state of a single shared line across the private first-level caches of the two cores in one cluster. Both first-level caches write through to the cluster's second-level cache and do not allocate on a write miss. Because the second-level copy is always current, a first-level copy is only ever Invalid, Shared or Exclusive. Each cycle the tracker takes at most one core request: a read or a write, the ID of the requesting core, and a flag that says the line was pushed out of that core's cache by replacement. It then updates both per-core states and reports the worst-case latency of the access in cycles. Where an access overlaps a fill or an invalidation, the latency is the larger of the two costs, not their sum.

When neither core in the cluster holds the line, the tracker does not work out the cost itself. It raises a request to the cluster-level controller, holds off new requests, and waits for that controller to send back a latency figure. It then reports that figure and applies the state change for the access. The first-level hit, second-level read, second-level write, fill and invalidation costs are parameters.

Top module: `coh_cluster_tracker`

## Requirements
- R1: State encoding per core is 2'b00 Invalid, 2'b01 Shared, 2'b10 Exclusive. The value 2'b11 never appears. At most one core is Exclusive, and only while the other core is Invalid. After reset both cores are Invalid, `req_ready` is 1 and `lat_valid` is 0.
- R2: A read by a core whose copy is Shared or Exclusive, with `req_evicted` low, reports HIT_LAT (default 4) and changes no state.
- R3: A read by a core whose copy is Shared or Exclusive, with `req_evicted` high, reports max(L2_RD_LAT, FILL_LAT) and changes no state.
- R4: A read by a core whose copy is Invalid, while the other core holds Shared or Exclusive, sets both copies to Shared and reports max(L2_RD_LAT, FILL_LAT).
- R5: A read when both copies are Invalid raises `up_req` with `up_write` 0 in the cycle after acceptance. `req_ready` stays 0 and no request is taken until `up_ack`. One cycle after `up_ack`, `lat_cycles` equals the `up_lat` that came with it and the requesting core becomes Exclusive.
- R6: A write by an Exclusive core with `req_evicted` low reports HIT_LAT + L2_WR_LAT and the core stays Exclusive.
- R7: A write by a Shared core with `req_evicted` low makes the writer Exclusive and the other core Invalid. It reports max(HIT_LAT + L2_WR_LAT, INV_LAT).
- R8: A write with `req_evicted` high on an Exclusive copy reports L2_WR_LAT and leaves the writer Invalid. On a Shared copy it reports max(L2_WR_LAT, INV_LAT) and leaves both cores Invalid.
- R9: A write by an Invalid core while the other core holds a copy leaves the writer Invalid (no allocation), makes the other core Invalid, and reports max(L2_WR_LAT, INV_LAT).
- R10: A write when both copies are Invalid raises `up_req` with `up_write` 1. One cycle after `up_ack` it reports the returned `up_lat` and leaves both states unchanged.
- R11: `lat_valid` is a one-cycle pulse one cycle after a locally resolved request is accepted, or one cycle after `up_ack`. An `up_ack` while no escalation is pending is ignored.
- R12: `req_evicted` has no effect on a request whose own copy is Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A core request is presented |
| req_ready | output | 1 | The tracker can take a request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_core | input | 1 | ID of the requesting core (0 or 1) |
| req_evicted | input | 1 | The requester's copy was lost to replacement |
| up_req | output | 1 | Escalation to the cluster-level controller is pending |
| up_write | output | 1 | The pending escalation is a write |
| up_ack | input | 1 | The cluster-level controller returns its latency |
| up_lat | input | LAT_W | Latency returned with `up_ack` |
| lat_valid | output | 1 | `lat_cycles` holds a new result |
| lat_cycles | output | LAT_W | Worst-case latency of the last access |
| l1_state | output | 4 | Core 0 state in [1:0], core 1 state in [3:2] |

## Verification
A wrong internal state leaves no mark on the access that causes it. It shows up on the next request that touches the line: a wrong latency class, an escalation that should not happen, or a missed one. The bench therefore compares `l1_state` against its own model in the same cycle as every latency check. Each random access also uses the states left by the accesses before it, so a bad transition is caught within one or two requests. During an escalation, the bench drives a competing request and a stray reply. These show at the ports whether the pending wait is dropped, repeated or overrun.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10
  } l1_state_e;

  localparam int unsigned NUM_CORES = 2;
  localparam int unsigned ST_W      = 2;

  function automatic int unsigned lat_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/coh_decide.sv
module coh_decide
  import coh_pkg::*;
#(
  parameter int unsigned LAT_W     = 16,
  parameter int unsigned HIT_LAT   = 4,
  parameter int unsigned L2_RD_LAT = 14,
  parameter int unsigned L2_WR_LAT = 14,
  parameter int unsigned FILL_LAT  = 10,
  parameter int unsigned INV_LAT   = 20
) (
  input  l1_state_e         own_st,
  input  l1_state_e         peer_st,
  input  logic              is_write,
  input  logic              evicted,
  output l1_state_e         own_nxt,
  output l1_state_e         peer_nxt,
  output logic [LAT_W-1:0]  lat,
  output logic              escalate
);

  localparam int unsigned RD_HIT   = HIT_LAT;
  localparam int unsigned RD_FILL  = lat_max(L2_RD_LAT, FILL_LAT);
  localparam int unsigned WR_HIT_E = HIT_LAT + L2_WR_LAT;
  localparam int unsigned WR_HIT_S = lat_max(HIT_LAT + L2_WR_LAT, INV_LAT);
  localparam int unsigned WR_THRU  = L2_WR_LAT;
  localparam int unsigned WR_INV   = lat_max(L2_WR_LAT, INV_LAT);

  logic own_held;
  logic peer_held;

  assign own_held  = (own_st != ST_I);
  assign peer_held = (peer_st != ST_I);

  always_comb begin
    own_nxt  = own_st;
    peer_nxt = peer_st;
    lat      = '0;
    escalate = 1'b0;
    if (!is_write) begin
      if (own_held) begin
        lat = evicted ? LAT_W'(RD_FILL) : LAT_W'(RD_HIT);
      end else if (peer_held) begin
        own_nxt  = ST_S;
        peer_nxt = ST_S;
        lat      = LAT_W'(RD_FILL);
      end else begin
        escalate = 1'b1;
      end
    end else begin
      if (own_st == ST_E) begin
        if (evicted) begin
          own_nxt = ST_I;
          lat     = LAT_W'(WR_THRU);
        end else begin
          lat     = LAT_W'(WR_HIT_E);
        end
      end else if (own_st == ST_S) begin
        peer_nxt = ST_I;
        if (evicted) begin
          own_nxt = ST_I;
          lat     = LAT_W'(WR_INV);
        end else begin
          own_nxt = ST_E;
          lat     = LAT_W'(WR_HIT_S);
        end
      end else if (peer_held) begin
        peer_nxt = ST_I;
        lat      = LAT_W'(WR_INV);
      end else begin
        escalate = 1'b1;
      end
    end
  end

endmodule

// File: rtl/coh_escalate.sv
module coh_escalate (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_write,
  input  logic start_core,
  input  logic up_ack,
  output logic busy,
  output logic up_req,
  output logic up_write,
  output logic fire,
  output logic pend_core,
  output logic pend_write
);

  logic wait_q, wait_d;
  logic write_q, write_d;
  logic core_q, core_d;
  logic cap_en;

  assign cap_en = start && !wait_q;
  assign fire   = wait_q && up_ack;

  always_comb begin
    wait_d  = wait_q;
    write_d = write_q;
    core_d  = core_q;
    if (cap_en) begin
      wait_d  = 1'b1;
      write_d = start_write;
      core_d  = start_core;
    end else if (fire) begin
      wait_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q  <= 1'b0;
      write_q <= 1'b0;
      core_q  <= 1'b0;
    end else begin
      wait_q  <= wait_d;
      write_q <= write_d;
      core_q  <= core_d;
    end
  end

  assign busy       = wait_q;
  assign up_req     = wait_q;
  assign up_write   = write_q;
  assign pend_core  = core_q;
  assign pend_write = write_q;

  // R5: a pending escalation is held until the reply arrives
  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && !up_ack) |=> up_req);

  // R5: no new escalation is started while one is pending
  assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |-> !start);

  // R10: the direction of the escalation is stable while it waits
  assert_dir_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && $past(up_req)) |-> $stable(up_write));

endmodule

// File: rtl/coh_l1_state.sv
module coh_l1_state
  import coh_pkg::*;
#(
  parameter int unsigned NC = NUM_CORES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NC-1:0]            en,
  input  logic [NC-1:0][ST_W-1:0]  nxt,
  output logic [NC-1:0][ST_W-1:0]  cur
);

  for (genvar g = 0; g < NC; g++) begin : g_core
    logic [ST_W-1:0] st_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= ST_I;
      end else if (en[g]) begin
        st_q <= nxt[g];
      end
    end

    assign cur[g] = st_q;

    // R1: no modified encoding is ever held by a write-through copy
    assert_no_mod_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != 2'b11);
  end

endmodule

// File: rtl/coh_cluster_tracker.sv
module coh_cluster_tracker
  import coh_pkg::*;
#(
  parameter int unsigned LAT_W     = 16,
  parameter int unsigned HIT_LAT   = 4,
  parameter int unsigned L2_RD_LAT = 14,
  parameter int unsigned L2_WR_LAT = 14,
  parameter int unsigned FILL_LAT  = 10,
  parameter int unsigned INV_LAT   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_core,
  input  logic             req_evicted,
  output logic             up_req,
  output logic             up_write,
  input  logic             up_ack,
  input  logic [LAT_W-1:0] up_lat,
  output logic             lat_valid,
  output logic [LAT_W-1:0] lat_cycles,
  output logic [3:0]       l1_state
);

  localparam int unsigned NC = NUM_CORES;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ns     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ns     <= rst_meta_q;
    end
  end

  logic [NC-1:0][ST_W-1:0] st_q;
  logic [NC-1:0][ST_W-1:0] st_nxt;
  logic [NC-1:0]           st_en;

  logic       busy, fire, pend_core, pend_write, accept, escalate;
  l1_state_e  own_st, peer_st, own_nxt, peer_nxt;
  logic [LAT_W-1:0] dec_lat;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign own_st    = l1_state_e'(st_q[req_core]);
  assign peer_st   = l1_state_e'(st_q[~req_core]);

  coh_decide #(
    .LAT_W(LAT_W), .HIT_LAT(HIT_LAT), .L2_RD_LAT(L2_RD_LAT),
    .L2_WR_LAT(L2_WR_LAT), .FILL_LAT(FILL_LAT), .INV_LAT(INV_LAT)
  ) i_decide (
    .own_st   (own_st),
    .peer_st  (peer_st),
    .is_write (req_write),
    .evicted  (req_evicted),
    .own_nxt  (own_nxt),
    .peer_nxt (peer_nxt),
    .lat      (dec_lat),
    .escalate (escalate)
  );

  coh_escalate i_escalate (
    .clk         (clk),
    .rst_n       (rst_ns),
    .start       (accept && escalate),
    .start_write (req_write),
    .start_core  (req_core),
    .up_ack      (up_ack),
    .busy        (busy),
    .up_req      (up_req),
    .up_write    (up_write),
    .fire        (fire),
    .pend_core   (pend_core),
    .pend_write  (pend_write)
  );

  always_comb begin
    st_en  = '0;
    st_nxt = st_q;
    if (accept && !escalate) begin
      st_en             = '1;
      st_nxt[req_core]  = own_nxt;
      st_nxt[~req_core] = peer_nxt;
    end else if (fire && !pend_write) begin
      st_en[pend_core]  = 1'b1;
      st_nxt[pend_core] = ST_E;
    end
  end

  coh_l1_state #(.NC(NC)) i_state (
    .clk   (clk),
    .rst_n (rst_ns),
    .en    (st_en),
    .nxt   (st_nxt),
    .cur   (st_q)
  );

  // latency result register
  logic             vld_d, vld_q;
  logic [LAT_W-1:0] lat_d, lat_q;
  logic             lat_en;

  always_comb begin
    vld_d  = (accept && !escalate) || fire;
    lat_en = vld_d;
    lat_d  = fire ? up_lat : dec_lat;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      vld_q <= 1'b0;
      lat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (lat_en) lat_q <= lat_d;
    end
  end

  assign lat_valid  = vld_q;
  assign lat_cycles = lat_q;
  assign l1_state   = {st_q[1], st_q[0]};

  // R1: an exclusive copy excludes any copy in the other core
  assert_excl_alone_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    (l1_state[1:0] == 2'b10 || l1_state[3:2] == 2'b10) |->
      (l1_state[1:0] == 2'b00 || l1_state[3:2] == 2'b00));

  // R5: requests are held off while the cluster level is consulted
  assert_stall_while_pending_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    up_req |-> !req_ready);

  // R11: the reply latency is reported in the cycle after the reply
  assert_reply_reported_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (up_req && up_ack) |=> (lat_valid && lat_cycles == $past(up_lat)));

  // R2: a clean read hit costs the hit time and leaves states alone
  assert_read_hit_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && req_ready && !req_write && !req_evicted &&
     ((req_core ? l1_state[3:2] : l1_state[1:0]) != 2'b00))
    |=> (lat_valid && lat_cycles == LAT_W'(HIT_LAT) && $stable(l1_state)));

endmodule

// File: tb/test_coh_cluster_tracker.sv
module test_coh_cluster_tracker;

  localparam int LW   = 16;
  localparam int T_HIT = 4, T_L2R = 14, T_L2W = 14, T_FILL = 10, T_INV = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_core, req_evicted, up_ack;
  logic [LW-1:0] up_lat;
  logic req_ready, up_req, up_write, lat_valid;
  logic [LW-1:0] lat_cycles;
  logic [3:0] l1_state;

  int nchk = 0;
  int nerr = 0;
  logic [1:0] m_st [2];

  always #2 clk = ~clk;

  coh_cluster_tracker i_coh_cluster_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_core(req_core), .req_evicted(req_evicted),
    .up_req(up_req), .up_write(up_write), .up_ack(up_ack), .up_lat(up_lat),
    .lat_valid(lat_valid), .lat_cycles(lat_cycles), .l1_state(l1_state)
  );

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(string rq, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // model of the requirements: 0 = I, 1 = S, 2 = E
  task automatic ref_model(input logic w, input logic [1:0] o, input logic [1:0] p,
                           input logic ev, output logic [1:0] on, output logic [1:0] pn,
                           output int lat, output logic esc, output string rq);
    on = o; pn = p; lat = 0; esc = 1'b0; rq = "R12";
    if (!w) begin
      if (o != 0) begin
        lat = ev ? mx(T_L2R, T_FILL) : T_HIT;
        rq  = ev ? "R3" : "R2";
      end else if (p != 0) begin
        on = 1; pn = 1; lat = mx(T_L2R, T_FILL);
        rq = ev ? "R12" : "R4";
      end else begin
        esc = 1'b1; rq = ev ? "R12" : "R5";
      end
    end else begin
      if (o == 2) begin
        if (ev) begin on = 0; lat = T_L2W; rq = "R8"; end
        else begin lat = T_HIT + T_L2W; rq = "R6"; end
      end else if (o == 1) begin
        pn = 0;
        if (ev) begin on = 0; lat = mx(T_L2W, T_INV); rq = "R8"; end
        else begin on = 2; lat = mx(T_HIT + T_L2W, T_INV); rq = "R7"; end
      end else if (p != 0) begin
        pn = 0; lat = mx(T_L2W, T_INV); rq = ev ? "R12" : "R9";
      end else begin
        esc = 1'b1; rq = ev ? "R12" : "R10";
      end
    end
  endtask

  task automatic chk_states(string rq);
    chk(rq, "core0 state", int'(l1_state[1:0]), int'(m_st[0]));
    chk(rq, "core1 state", int'(l1_state[3:2]), int'(m_st[1]));
  endtask

  task automatic do_op(input logic w, input logic c, input logic ev,
                       input int wait_cyc, input logic [LW-1:0] reply);
    logic [1:0] on, pn;
    int lat;
    logic esc;
    string rq;
    ref_model(w, m_st[c], m_st[~c], ev, on, pn, lat, esc, rq);
    @(negedge clk);
    chk(rq, "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_write = w; req_core = c; req_evicted = ev;
    @(negedge clk);
    req_valid = 1'b0;
    if (!esc) begin
      m_st[c] = on; m_st[~c] = pn;
      chk(rq, "lat_valid", int'(lat_valid), 1);
      chk(rq, "latency", int'(lat_cycles), lat);
      chk_states(rq);
    end else begin
      chk(rq, "up_req", int'(up_req), 1);
      chk(rq, "up_write", int'(up_write), int'(w));
      chk(rq, "no early lat_valid", int'(lat_valid), 0);
      chk("R5", "ready low while pending", int'(req_ready), 0);
      // competing request while stalled must not be taken (R5)
      req_valid = 1'b1; req_write = 1'b0; req_core = ~c; req_evicted = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R5", "stall keeps states", int'(l1_state), int'({m_st[1], m_st[0]}));
      chk("R5", "no result during stall", int'(lat_valid), 0);
      for (int k = 0; k < wait_cyc; k++) @(negedge clk);
      up_ack = 1'b1; up_lat = reply;
      @(negedge clk);
      up_ack = 1'b0;
      if (!w) m_st[c] = 2;
      chk(rq, "lat_valid after reply", int'(lat_valid), 1);
      chk(rq, "reply latency", int'(lat_cycles), int'(reply));
      chk(rq, "up_req cleared", int'(up_req), 0);
      chk_states(rq);
    end
    @(negedge clk);
    chk("R11", "lat_valid single pulse", int'(lat_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_core = 1'b0;
    req_evicted = 1'b0; up_ack = 1'b0; up_lat = '0;
    m_st[0] = 0; m_st[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1", "reset states", int'(l1_state), 0);
    chk("R1", "reset ready", int'(req_ready), 1);
    chk("R1", "reset lat_valid", int'(lat_valid), 0);
    chk("R1", "reset up_req", int'(up_req), 0);

    // stray reply while idle (R11)
    up_ack = 1'b1; up_lat = 16'd999;
    @(negedge clk);
    up_ack = 1'b0;
    chk("R11", "stray reply ignored", int'(lat_valid), 0);
    chk("R11", "stray reply keeps states", int'(l1_state), 0);

    do_op(1'b0, 1'b0, 1'b0, 2, 16'd42);   // R5 read miss in cluster
    do_op(1'b0, 1'b0, 1'b0, 0, 16'd0);    // R2
    do_op(1'b1, 1'b0, 1'b0, 0, 16'd0);    // R6
    do_op(1'b0, 1'b1, 1'b0, 0, 16'd0);    // R4
    do_op(1'b0, 1'b1, 1'b1, 0, 16'd0);    // R3
    do_op(1'b1, 1'b0, 1'b0, 0, 16'd0);    // R7
    do_op(1'b0, 1'b1, 1'b1, 0, 16'd0);    // R12 evicted flag on invalid copy
    do_op(1'b1, 1'b0, 1'b1, 0, 16'd0);    // R8 shared, evicted
    do_op(1'b1, 1'b1, 1'b0, 1, 16'd77);   // R10
    do_op(1'b1, 1'b1, 1'b1, 0, 16'd55);   // R12 write miss with evicted flag
    do_op(1'b0, 1'b1, 1'b0, 0, 16'd300);  // R5
    do_op(1'b1, 1'b1, 1'b1, 0, 16'd0);    // R8 exclusive, evicted
    do_op(1'b0, 1'b0, 1'b0, 3, 16'hffff); // R5 at the width limit
    do_op(1'b1, 1'b1, 1'b0, 0, 16'd0);    // R9

    for (int i = 0; i < 400; i++) begin
      do_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)),
            LW'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule